// File: doc/BRIEF.md
# Two-Input Layer Alpha Blender

This block is one stage of a pixel compositing cascade. Each clock it takes a top-layer pixel, made of three colour channels plus its own alpha, and a bottom-layer pixel that comes from the stage below. It produces one output pixel, two cycles later, with a valid flag carried alongside. When no stage is wired underneath, a programmable background colour stands in for the bottom input. A window-active flag travels with each stream, so each stage knows where its plane actually covers the screen.

A frame-start strobe latches a small set of configuration inputs. These set the layer mode, the source of the effective alpha, whether the top colour is already premultiplied, the plane alpha, the gain, the background colour, the overlap-only restriction and whether a bottom stage is present. Pixels entering afterwards use that latched set until the next strobe. A cascade is built by feeding one stage's output pixel and active flag into the bottom inputs of the next.

Top module: `layer_blend_stage`

## Requirements
- R1: An input pixel accepted with `top_valid_i` high at clock edge k appears on the outputs with `out_valid_o` high after edge k+2. `out_valid_o` is low in every other cycle. Reset clears `out_valid_o` and `out_rgb_o` to zero.
- R2: The configuration inputs are captured only at a clock edge where `frame_start_i` is high, and they govern pixels accepted at later edges. Changes to them at any other time have no effect on the output.
- R3: Layer mode encoding: 0 outputs the bottom input unchanged, 1 outputs the top pixel unchanged, 2 blends the top pixel over the background colour and ignores the bottom input, 3 blends the top over the bottom.
- R4: Alpha source encoding: 0 uses the pixel alpha, 1 uses (pixel_alpha*gain+127)/255 with integer division, 2 uses the plane alpha and ignores the pixel alpha, 3 behaves as 0.
- R5: Without premultiplication each channel is (top*a + bottom*(255-a) + 127)/255.
- R6: With premultiplication each channel is top + (bottom*(255-a)+127)/255, saturated at 255.
- R7: When the bottom-present setting is 0, the background colour replaces the bottom input and counts as an active bottom window.
- R8: In mode 3, a pixel where both windows are active is blended. Where only the top is active the top passes unchanged, where only the bottom is active the bottom passes, and where neither is active the background colour is output. In mode 2 the background colour is output where the top window is inactive.
- R9: With overlap-only set in mode 3, a pixel where only the top window is active outputs the bottom input, not the top.
- R10: `out_active_o` equals the bottom-active flag in mode 0 and the top-active flag in mode 1. It is always 1 in mode 2. In mode 3 it is 1 when the bottom is active or when the top is active with overlap-only clear.
- R11: The colour word packs red in bits 23:16, green in 15:8 and blue in 7:0. All channels use the same arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Latch configuration at this edge |
| cfg_layer_mode_i | input | 2 | Layer mode (R3) |
| cfg_alpha_src_i | input | 2 | Alpha source (R4) |
| cfg_premult_i | input | 1 | Top colour already premultiplied |
| cfg_plane_alpha_i | input | 8 | Plane alpha |
| cfg_gain_i | input | 8 | Global gain applied to pixel alpha |
| cfg_bg_rgb_i | input | 24 | Background colour |
| cfg_overlap_only_i | input | 1 | Blend only where both layers are present |
| cfg_bot_present_i | input | 1 | A bottom stage is connected |
| top_valid_i | input | 1 | Pixel valid |
| top_rgb_i | input | 24 | Top colour |
| top_alpha_i | input | 8 | Top pixel alpha |
| top_active_i | input | 1 | Top window active |
| bot_rgb_i | input | 24 | Bottom colour from the stage below |
| bot_active_i | input | 1 | Bottom window active |
| out_valid_o | output | 1 | Output valid |
| out_rgb_o | output | 24 | Output colour |
| out_active_o | output | 1 | Output window active |

## Verification
The hardest situation to create is a configuration change racing pixels already in the pipe. A strobe lands while earlier pixels are still in flight, and settings are also changed with no strobe at all. The stimulus applies a setting, then alters the configuration inputs without a strobe and streams pixels that must still follow the old setting. The other hard area is the set of window combinations in blend mode with overlap-only on and off, with and without a bottom stage. These are walked exhaustively, and random colours and alphas are mixed in, including the alpha extremes and the premultiplied saturation point.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    LM_BYPASS   = 2'd0,
    LM_TOP_PASS = 2'd1,
    LM_TOP_ONLY = 2'd2,
    LM_BLEND    = 2'd3
  } layer_mode_e;

  typedef enum logic [1:0] {
    AS_PIXEL      = 2'd0,
    AS_PIXEL_GAIN = 2'd1,
    AS_PLANE      = 2'd2,
    AS_RSVD       = 2'd3
  } alpha_src_e;

  typedef enum logic [1:0] {
    PICK_TOP = 2'd0,
    PICK_BOT = 2'd1,
    PICK_BG  = 2'd2,
    PICK_MIX = 2'd3
  } pick_e;
endpackage

// File: rtl/lb_alpha_sel.sv
module lb_alpha_sel
  import lb_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  alpha_src_e    src_i,
  input  logic [CW-1:0] pix_alpha_i,
  input  logic [CW-1:0] gain_i,
  input  logic [CW-1:0] plane_alpha_i,
  output logic [CW-1:0] alpha_o
);
  localparam int MAXV = (1 << CW) - 1;
  localparam int PW   = 2 * CW + 1;

  logic [PW-1:0] prod;
  logic [CW-1:0] scaled;

  assign prod   = PW'(pix_alpha_i) * PW'(gain_i) + PW'(MAXV / 2);
  assign scaled = CW'(prod / PW'(MAXV));

  always_comb begin
    unique case (src_i)
      AS_PIXEL_GAIN: alpha_o = scaled;
      AS_PLANE:      alpha_o = plane_alpha_i;
      default:       alpha_o = pix_alpha_i;
    endcase
  end

  // R4
  gain_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == AS_PIXEL_GAIN) |-> (alpha_o <= pix_alpha_i && alpha_o <= gain_i));
endmodule

// File: rtl/lb_route.sv
module lb_route
  import lb_pkg::*;
(
  input  layer_mode_e mode_i,
  input  logic        overlap_only_i,
  input  logic        bot_present_i,
  input  logic        top_act_i,
  input  logic        bot_act_i,
  output pick_e       pick_o,
  output logic        bot_is_bg_o,
  output logic        act_o
);
  logic bot_en;
  assign bot_en      = bot_present_i ? bot_act_i : 1'b1;
  assign bot_is_bg_o = !bot_present_i || (mode_i == LM_TOP_ONLY);

  always_comb begin
    pick_o = PICK_BOT;
    act_o  = bot_en;
    unique case (mode_i)
      LM_BYPASS: begin
        pick_o = PICK_BOT;
        act_o  = bot_en;
      end
      LM_TOP_PASS: begin
        pick_o = PICK_TOP;
        act_o  = top_act_i;
      end
      LM_TOP_ONLY: begin
        pick_o = top_act_i ? PICK_MIX : PICK_BG;
        act_o  = 1'b1;
      end
      LM_BLEND: begin
        act_o = (top_act_i && !overlap_only_i) || bot_en;
        if (top_act_i && bot_en)      pick_o = PICK_MIX;
        else if (top_act_i)           pick_o = overlap_only_i ? PICK_BOT : PICK_TOP;
        else if (bot_en)              pick_o = PICK_BOT;
        else                          pick_o = PICK_BG;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lb_mix_ch.sv
module lb_mix_ch #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          premult_i,
  input  logic [CW-1:0] alpha_i,
  input  logic [CW-1:0] top_i,
  input  logic [CW-1:0] bot_i,
  output logic [CW-1:0] mix_o
);
  localparam int MAXV = (1 << CW) - 1;
  localparam int PW   = 2 * CW + 1;
  localparam int CW1  = CW + 1;

  logic [CW-1:0] inv_a;
  logic [PW-1:0] t_term, b_term, plain_sum, b_scaled;
  logic [CW-1:0] plain_res;
  logic [CW:0]   pm_sum;
  logic [CW-1:0] pm_res;

  assign inv_a     = CW'(MAXV) - alpha_i;
  assign t_term    = PW'(top_i) * PW'(alpha_i);
  assign b_term    = PW'(bot_i) * PW'(inv_a);
  assign plain_sum = t_term + b_term + PW'(MAXV / 2);
  assign plain_res = CW'(plain_sum / PW'(MAXV));
  assign b_scaled  = (b_term + PW'(MAXV / 2)) / PW'(MAXV);
  assign pm_sum    = {1'b0, top_i} + CW1'(b_scaled);
  assign pm_res    = pm_sum[CW] ? {CW{1'b1}} : pm_sum[CW-1:0];
  assign mix_o     = premult_i ? pm_res : plain_res;

  // R5
  opaque_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !premult_i && alpha_i == CW'(MAXV)) |-> (mix_o == top_i));
  // R5
  clear_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !premult_i && alpha_i == '0) |-> (mix_o == bot_i));
  // R6
  pm_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && premult_i) |-> (mix_o >= top_i));
endmodule

// File: rtl/layer_blend_stage.sv
module layer_blend_stage
  import lb_pkg::*;
#(
  parameter int CW  = 8,
  parameter int NCH = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic [1:0]          cfg_layer_mode_i,
  input  logic [1:0]          cfg_alpha_src_i,
  input  logic                cfg_premult_i,
  input  logic [CW-1:0]       cfg_plane_alpha_i,
  input  logic [CW-1:0]       cfg_gain_i,
  input  logic [CW*NCH-1:0]   cfg_bg_rgb_i,
  input  logic                cfg_overlap_only_i,
  input  logic                cfg_bot_present_i,
  input  logic                top_valid_i,
  input  logic [CW*NCH-1:0]   top_rgb_i,
  input  logic [CW-1:0]       top_alpha_i,
  input  logic                top_active_i,
  input  logic [CW*NCH-1:0]   bot_rgb_i,
  input  logic                bot_active_i,
  output logic                out_valid_o,
  output logic [CW*NCH-1:0]   out_rgb_o,
  output logic                out_active_o
);
  localparam int PXW = CW * NCH;

  // latched configuration
  layer_mode_e    mode_q;
  alpha_src_e     asrc_q;
  logic           premult_q, overlap_q, bot_present_q;
  logic [CW-1:0]  plane_q, gain_q;
  logic [PXW-1:0] bg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q        <= LM_BYPASS;
      asrc_q        <= AS_PIXEL;
      premult_q     <= 1'b0;
      overlap_q     <= 1'b0;
      bot_present_q <= 1'b0;
      plane_q       <= '0;
      gain_q        <= '0;
      bg_q          <= '0;
    end else if (frame_start_i) begin
      mode_q        <= layer_mode_e'(cfg_layer_mode_i);
      asrc_q        <= alpha_src_e'(cfg_alpha_src_i);
      premult_q     <= cfg_premult_i;
      overlap_q     <= cfg_overlap_only_i;
      bot_present_q <= cfg_bot_present_i;
      plane_q       <= cfg_plane_alpha_i;
      gain_q        <= cfg_gain_i;
      bg_q          <= cfg_bg_rgb_i;
    end
  end

  // stage 1: alpha resolution and routing
  logic [CW-1:0] alpha_c;
  pick_e         pick_c;
  logic          bot_is_bg_c, act_c;
  logic [PXW-1:0] bot_c;

  lb_alpha_sel #(.CW(CW)) i_alpha (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .src_i        (asrc_q),
    .pix_alpha_i  (top_alpha_i),
    .gain_i       (gain_q),
    .plane_alpha_i(plane_q),
    .alpha_o      (alpha_c)
  );

  lb_route i_route (
    .mode_i        (mode_q),
    .overlap_only_i(overlap_q),
    .bot_present_i (bot_present_q),
    .top_act_i     (top_active_i),
    .bot_act_i     (bot_active_i),
    .pick_o        (pick_c),
    .bot_is_bg_o   (bot_is_bg_c),
    .act_o         (act_c)
  );

  assign bot_c = (bot_is_bg_c || pick_c == PICK_BG) ? bg_q : bot_rgb_i;

  logic           s1_valid, s1_premult, s1_act;
  pick_e          s1_pick;
  logic [CW-1:0]  s1_alpha;
  logic [PXW-1:0] s1_top, s1_bot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid   <= 1'b0;
      s1_premult <= 1'b0;
      s1_act     <= 1'b0;
      s1_pick    <= PICK_BOT;
      s1_alpha   <= '0;
      s1_top     <= '0;
      s1_bot     <= '0;
    end else begin
      s1_valid <= top_valid_i;
      if (top_valid_i) begin
        s1_premult <= premult_q;
        s1_act     <= act_c;
        s1_pick    <= pick_c;
        s1_alpha   <= alpha_c;
        s1_top     <= top_rgb_i;
        s1_bot     <= bot_c;
      end
    end
  end

  // stage 2: per-channel arithmetic and output select
  logic [PXW-1:0] mix_rgb;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lb_mix_ch #(.CW(CW)) i_mix (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (s1_valid),
      .premult_i(s1_premult),
      .alpha_i  (s1_alpha),
      .top_i    (s1_top[c*CW +: CW]),
      .bot_i    (s1_bot[c*CW +: CW]),
      .mix_o    (mix_rgb[c*CW +: CW])
    );
  end

  logic [PXW-1:0] out_c;
  always_comb begin
    unique case (s1_pick)
      PICK_TOP: out_c = s1_top;
      PICK_MIX: out_c = mix_rgb;
      default:  out_c = s1_bot;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_rgb_o    <= '0;
      out_active_o <= 1'b0;
    end else begin
      out_valid_o <= s1_valid;
      if (s1_valid) begin
        out_rgb_o    <= out_c;
        out_active_o <= s1_act;
      end
    end
  end

  // cycles since reset, saturating, for history-based checks
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (out_valid_o == $past(top_valid_i, 2)));
  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && !$past(frame_start_i)) |->
      ($stable(mode_q) && $stable(asrc_q) && $stable(bg_q) && $stable(premult_q)));
endmodule

// File: tb/test_layer_blend_stage.sv
module test_layer_blend_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic [1:0]  c_mode = '0, c_asrc = '0;
  logic        c_pm = 1'b0, c_ovl = 1'b0, c_bp = 1'b0;
  logic [7:0]  c_pa = '0, c_gain = '0;
  logic [23:0] c_bg = '0;
  logic        t_valid = 1'b0, t_act = 1'b0, b_act = 1'b0;
  logic [23:0] t_rgb = '0, b_rgb = '0;
  logic [7:0]  t_a = '0;
  logic        o_valid, o_act;
  logic [23:0] o_rgb;

  always #2.5 clk = ~clk;

  layer_blend_stage i_layer_blend_stage (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs),
    .cfg_layer_mode_i(c_mode), .cfg_alpha_src_i(c_asrc), .cfg_premult_i(c_pm),
    .cfg_plane_alpha_i(c_pa), .cfg_gain_i(c_gain), .cfg_bg_rgb_i(c_bg),
    .cfg_overlap_only_i(c_ovl), .cfg_bot_present_i(c_bp),
    .top_valid_i(t_valid), .top_rgb_i(t_rgb), .top_alpha_i(t_a), .top_active_i(t_act),
    .bot_rgb_i(b_rgb), .bot_active_i(b_act),
    .out_valid_o(o_valid), .out_rgb_o(o_rgb), .out_active_o(o_act)
  );

  typedef struct {
    logic [23:0] rgb;
    logic        act;
    int          due;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // applied configuration, as the bench believes it
  int m_mode, m_asrc, m_pa, m_gain;
  bit m_pm, m_ovl, m_bp;
  logic [23:0] m_bg;

  always @(posedge clk) cyc++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ch_mix(int t, int b, int a, bit pm);
    int v;
    if (pm) begin
      v = t + (b * (255 - a) + 127) / 255;
      if (v > 255) v = 255;
    end else begin
      v = (t * a + b * (255 - a) + 127) / 255;
    end
    return 8'(v);
  endfunction

  function automatic logic [23:0] px_mix(logic [23:0] t, logic [23:0] b, int a, bit pm);
    logic [23:0] r;
    for (int c = 0; c < 3; c++) r[c*8 +: 8] = ch_mix(int'(t[c*8 +: 8]), int'(b[c*8 +: 8]), a, pm);
    return r;
  endfunction

  task automatic set_cfg(int mode, int asrc, bit pm, int pa, int gain,
                         logic [23:0] bg, bit ovl, bit bp);
    @(negedge clk);
    t_valid = 1'b0; fs = 1'b1;
    c_mode = 2'(mode); c_asrc = 2'(asrc); c_pm = pm; c_pa = 8'(pa);
    c_gain = 8'(gain); c_bg = bg; c_ovl = ovl; c_bp = bp;
    m_mode = mode; m_asrc = asrc; m_pm = pm; m_pa = pa; m_gain = gain;
    m_bg = bg; m_ovl = ovl; m_bp = bp;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t_valid = 1'b0; fs = 1'b0;
    end
  endtask

  task automatic drive_px(logic [23:0] tr, int ta, bit ta_act,
                          logic [23:0] br, bit ba, string tag);
    item_t it;
    int a;
    bit bot_en;
    logic [23:0] bcol;
    @(negedge clk);
    fs = 1'b0; t_valid = 1'b1;
    t_rgb = tr; t_a = 8'(ta); t_act = ta_act; b_rgb = br; b_act = ba;
    case (m_asrc)
      1:       a = (ta * m_gain + 127) / 255;
      2:       a = m_pa;
      default: a = ta;
    endcase
    bot_en = m_bp ? ba : 1'b1;
    bcol   = (m_mode == 2 || !m_bp) ? m_bg : br;
    case (m_mode)
      0: begin it.rgb = bcol; it.act = bot_en; end
      1: begin it.rgb = tr; it.act = ta_act; end
      2: begin it.rgb = ta_act ? px_mix(tr, m_bg, a, m_pm) : m_bg; it.act = 1'b1; end
      default: begin
        it.act = (ta_act && !m_ovl) || bot_en;
        if (ta_act && bot_en)  it.rgb = px_mix(tr, bcol, a, m_pm);
        else if (ta_act)       it.rgb = m_ovl ? bcol : tr;
        else if (bot_en)       it.rgb = bcol;
        else                   it.rgb = m_bg;
      end
    endcase
    it.due = cyc + 2;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (o_valid) begin
        if (q.size() == 0) begin
          chk("R1 unexpected valid", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk({it.tag, " rgb"}, 32'(o_rgb), 32'(it.rgb));
          chk("R10 active", 32'(o_act), 32'(it.act));
          chk("R1 latency", 32'(cyc), 32'(it.due));
        end
      end else if (q.size() != 0 && q[0].due <= cyc) begin
        chk("R1 missing valid", 32'd0, 32'd1);
        void'(q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 32'(o_valid), 32'd0);
    chk("R1 reset rgb", 32'(o_rgb), 32'd0);
    rst_n = 1'b1;

    // R5 non-premultiplied blend with pixel alpha, alpha extremes
    set_cfg(3, 0, 0, 0, 0, 24'h102030, 0, 1);
    drive_px(24'hFF8000, 255, 1, 24'h00FF40, 1, "R5 a255");
    drive_px(24'hFF8000, 0,   1, 24'h00FF40, 1, "R5 a0");
    drive_px(24'hFF8000, 128, 1, 24'h00FF40, 1, "R5 a128 R11");
    drive_px(24'h123456, 77,  1, 24'hABCDEF, 1, "R5 a77");
    idle(1);
    drive_px(24'h010203, 200, 1, 24'hF0E0D0, 1, "R1 after gap");

    // R6 premultiplied, saturation
    set_cfg(3, 0, 1, 0, 0, 24'h0, 0, 1);
    drive_px(24'hF0F0F0, 10,  1, 24'hFFFFFF, 1, "R6 saturate");
    drive_px(24'h102030, 100, 1, 24'h405060, 1, "R6 sum");
    drive_px(24'h000000, 255, 1, 24'hFFFFFF, 1, "R6 a255");

    // R4 alpha sources
    set_cfg(3, 1, 0, 0, 128, 24'h0, 0, 1);
    drive_px(24'hFFFFFF, 255, 1, 24'h000000, 1, "R4 gain");
    drive_px(24'h80FF00, 90,  1, 24'h00FF80, 1, "R4 gain b");
    set_cfg(3, 2, 0, 64, 0, 24'h0, 0, 1);
    drive_px(24'hFFFFFF, 255, 1, 24'h000000, 1, "R4 plane ignores pix");
    drive_px(24'hFFFFFF, 0,   1, 24'h000000, 1, "R4 plane ignores pix b");
    set_cfg(3, 3, 0, 64, 0, 24'h0, 0, 1);
    drive_px(24'hFFFFFF, 40,  1, 24'h000000, 1, "R4 reserved");

    // R3 modes
    set_cfg(0, 0, 0, 0, 0, 24'h777777, 0, 1);
    drive_px(24'hFFFFFF, 255, 1, 24'h123456, 1, "R3 bypass");
    drive_px(24'hFFFFFF, 255, 1, 24'h654321, 0, "R3 bypass inactive");
    set_cfg(1, 0, 0, 0, 0, 24'h777777, 0, 1);
    drive_px(24'hABCDEF, 30,  1, 24'h123456, 1, "R3 passthrough");
    drive_px(24'hABCDEF, 30,  0, 24'h123456, 1, "R3 passthrough inactive");
    set_cfg(2, 0, 0, 0, 0, 24'h204060, 0, 1);
    drive_px(24'hFFFFFF, 128, 1, 24'h999999, 1, "R3 top-only");
    drive_px(24'hFFFFFF, 128, 0, 24'h999999, 1, "R8 top-only inactive bg");

    // R7 no bottom stage
    set_cfg(3, 0, 0, 0, 0, 24'h4080C0, 0, 0);
    drive_px(24'hFFFFFF, 100, 1, 24'h000000, 0, "R7 bg bottom");
    drive_px(24'hFFFFFF, 100, 0, 24'h000000, 0, "R7 bg only");
    set_cfg(0, 0, 0, 0, 0, 24'h4080C0, 0, 0);
    drive_px(24'hFFFFFF, 100, 1, 24'h111111, 1, "R7 bypass bg");

    // R8 / R9 window combinations
    for (int ov = 0; ov < 2; ov++) begin
      set_cfg(3, 0, 0, 0, 0, 24'h0A0B0C, bit'(ov), 1);
      for (int w = 0; w < 4; w++)
        drive_px(24'hC0C0C0, 150, bit'(w & 1), 24'h303030, bit'(w >> 1),
                 ov ? "R9 overlap" : "R8 window");
    end

    // R2 config changes without strobe are ignored
    set_cfg(3, 0, 0, 0, 0, 24'h0, 0, 1);
    @(negedge clk);
    fs = 1'b0; c_mode = 2'd1; c_pm = 1'b1; c_bg = 24'hFFFFFF;
    drive_px(24'h804020, 60, 1, 24'h204080, 1, "R2 no strobe");
    drive_px(24'h804020, 60, 0, 24'h204080, 0, "R2 no strobe bg");
    // strobe while pixels in flight
    drive_px(24'h112233, 200, 1, 24'h445566, 1, "R2 before strobe");
    set_cfg(1, 0, 0, 0, 0, 24'h0, 0, 1);
    drive_px(24'h112233, 200, 1, 24'h445566, 1, "R2 after strobe");

    // random mix, back to back
    for (int k = 0; k < 400; k++) begin
      if (k % 50 == 0)
        set_cfg(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)), bit'($urandom_range(1, 0)),
                int'($urandom_range(255, 0)), int'($urandom_range(255, 0)), 24'($urandom),
                bit'($urandom_range(1, 0)), bit'($urandom_range(1, 0)));
      drive_px(24'($urandom), int'($urandom_range(255, 0)), bit'($urandom_range(1, 0)),
               24'($urandom), bit'($urandom_range(1, 0)), "R3 R4 R5 R6 random");
    end

    idle(6);
    chk("R1 drained", 32'(q.size()), 32'd0);
    finish_run();
  end
endmodule